// File: doc/BRIEF.md
# Phase-Accumulator Waveform Voice

This block is one tone voice for a synthesizer. A 24-bit phase register advances by a 16-bit frequency word on every system clock, so the tone frequency is clock·F/2^24. From the phase the voice shapes one of four digital waveforms: sawtooth, triangle, rectangle with a 12-bit duty threshold, or pseudo-random noise. The result is a 12-bit sample.

Software programs the voice through a byte-wide write port. The port holds the frequency word, the duty threshold and a control byte. The control byte picks the waveform and sets three special functions. A test bit freezes the oscillator at zero. Hard sync restarts the phase when a neighbouring voice's phase MSB rises. Ring modulation flips the triangle fold with that neighbour's MSB. The voice drives its own phase MSB out so that voices can be chained. It also returns the upper byte of its sample.

Top module: `wave_voice`

## Requirements
- R1: After reset the phase is 0, all registers are 0, the noise shift register holds 23'h7FFFF8, and `sample`, `readback` and `acc_msb` are 0.
- R2: A write with `wr_en` high stores `wr_data` on that clock edge. Address 0 is frequency bits 7:0 and address 1 is bits 15:8. From the next edge on, the phase increases by the frequency word every clock, modulo 2^24. `acc_msb` is phase bit 23.
- R3: With control byte 0x20 (bit 5 alone among bits 7:4), `sample` equals phase bits 23:12.
- R4: With control bit 4 alone selected, `sample` is phase bits 22:12 XORed with the fold bit and shifted left one place, with bit 0 zero. The fold bit is phase bit 23, or that bit XOR `sync_src_msb` when ring mode is on.
- R5: With control bit 6 alone selected, `sample` is 12'hFFF when phase bits 23:12 are at least the duty threshold, and 0 otherwise. The duty threshold comes from address 2 (bits 7:0) and address 3 bits 3:0. Bits 7:4 of the address-3 byte are ignored.
- R6: With control bit 7 alone selected, `sample` is formed from noise-register bits {22,20,16,13,11,7,4,2} as sample bits 11:4, and sample bits 3:0 are zero. The register shifts left one place, taking in bit22 XOR bit17. It shifts on the edge after the edge where phase bit 19 went from 0 to 1.
- R7: While control bit 3 (test) is set, each clock forces the phase to 0 and the noise register to 23'h7FFFF8.
- R8: With control bit 1 (sync) set, the phase is cleared on the edge after `sync_src_msb` is first seen high following a low sample. With sync clear, a rise of `sync_src_msb` has no effect on the phase.
- R9: Control bit 2 (ring) affects only the triangle fold as given in R4. It takes effect at once when `sync_src_msb` changes.
- R10: When none, or more than one, of control bits 7:4 is set, `sample` is 0.
- R11: `readback` always equals `sample[11:4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..4) |
| wr_data | input | 8 | Write data byte |
| sync_src_msb | input | 1 | Phase MSB of the neighbouring voice |
| sample | output | 12 | Waveform sample |
| acc_msb | output | 1 | Own phase MSB for chaining |
| readback | output | 8 | Upper 8 bits of the sample |

## Verification
The sawtooth exposes the phase almost bit for bit, and `acc_msb` exposes its top bit. A wrong phase step, a missed sync clear or a test bit that fails to hold therefore shows on the first sampled cycle after the fault. A noise register fault is slower to surface. It appears only after the next rising edge of phase bit 19, which the bench reaches within about sixteen clocks by running at the maximum frequency word. A wrong fold bit or duty compare shows as soon as the phase crosses the half-way point or the threshold. The bench therefore samples on both sides of those points.

// File: rtl/wv_pkg.sv
package wv_pkg;
  localparam int ACC_W  = 24;
  localparam int FREQ_W = 16;
  localparam int SMP_W  = 12;
  localparam int LFSR_W = 23;
  localparam int ADR_W  = 3;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h7FFFF8;

  localparam logic [ADR_W-1:0] A_FREQ_LO = 3'd0;
  localparam logic [ADR_W-1:0] A_FREQ_HI = 3'd1;
  localparam logic [ADR_W-1:0] A_DUTY_LO = 3'd2;
  localparam logic [ADR_W-1:0] A_DUTY_HI = 3'd3;
  localparam logic [ADR_W-1:0] A_MODE    = 3'd4;

  // control byte bits 7..1, bit 7 first
  typedef struct packed {
    logic sel_noise;
    logic sel_pulse;
    logic sel_saw;
    logic sel_tri;
    logic test;
    logic ring;
    logic sync;
  } mode_t;

  function automatic logic [SMP_W-1:0] saw_of(input logic [SMP_W-1:0] top);
    return top;
  endfunction

  function automatic logic [SMP_W-1:0] tri_of(input logic [SMP_W-1:0] top,
                                              input logic flip);
    logic m;
    m = top[SMP_W-1] ^ flip;
    return {top[SMP_W-2:0] ^ {(SMP_W-1){m}}, 1'b0};
  endfunction

  function automatic logic [SMP_W-1:0] pulse_of(input logic [SMP_W-1:0] top,
                                                input logic [SMP_W-1:0] duty);
    return (top >= duty) ? {SMP_W{1'b1}} : '0;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] l);
    return {l[LFSR_W-2:0], l[22] ^ l[17]};
  endfunction

  function automatic logic [SMP_W-1:0] noise_of(input logic [LFSR_W-1:0] l);
    return {l[22], l[20], l[16], l[13], l[11], l[7], l[4], l[2], 4'b0000};
  endfunction
endpackage

// File: rtl/wv_regs.sv
module wv_regs
  import wv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  output logic [FREQ_W-1:0] freq,
  output logic [SMP_W-1:0]  duty,
  output mode_t             mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq <= '0;
      duty <= '0;
      mode <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_FREQ_LO: freq[7:0]        <= wr_data;
        A_FREQ_HI: freq[15:8]       <= wr_data;
        A_DUTY_LO: duty[7:0]        <= wr_data;
        A_DUTY_HI: duty[SMP_W-1:8]  <= wr_data[SMP_W-9:0];
        A_MODE:    mode             <= mode_t'(wr_data[7:1]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wv_phase.sv
module wv_phase
  import wv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  input  logic              test,
  input  logic              sync_en,
  input  logic              src_msb,
  output logic [ACC_W-1:0]  acc,
  output logic              sync_hit
);
  logic src_q;

  assign sync_hit = sync_en & src_msb & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      src_q <= 1'b0;
    end else begin
      src_q <= src_msb;
      if (test || sync_hit) acc <= '0;
      else                  acc <= acc + ACC_W'(freq);
    end
  end

  p_test_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test |=> (acc == '0));
  p_sync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (acc == '0));
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!test && !sync_hit) |=> (acc - $past(acc) == ACC_W'($past(freq))));
endmodule

// File: rtl/wv_noise.sv
module wv_noise
  import wv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test,
  input  logic             phase_b19,
  output logic [SMP_W-1:0] noise_word,
  output logic             step
);
  logic [LFSR_W-1:0] lfsr;
  logic              b19_q;

  assign step       = phase_b19 & ~b19_q & ~test;
  assign noise_word = noise_of(lfsr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr  <= LFSR_SEED;
      b19_q <= 1'b0;
    end else if (test) begin
      lfsr  <= LFSR_SEED;
      b19_q <= 1'b0;
    end else begin
      b19_q <= phase_b19;
      if (step) lfsr <= lfsr_next(lfsr);
    end
  end

  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !test) |=> $stable(lfsr));
  p_lfsr_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test |=> (lfsr == LFSR_SEED));
endmodule

// File: rtl/wv_shaper.sv
module wv_shaper
  import wv_pkg::*;
(
  input  logic [3:0]       sel,
  input  logic [SMP_W-1:0] top,
  input  logic [SMP_W-1:0] duty,
  input  logic [SMP_W-1:0] noise_word,
  input  logic             ring,
  input  logic             src_msb,
  output logic [SMP_W-1:0] sample
);
  always_comb begin
    case (sel)
      4'b1000: sample = noise_word;
      4'b0100: sample = pulse_of(top, duty);
      4'b0010: sample = saw_of(top);
      4'b0001: sample = tri_of(top, ring & src_msb);
      default: sample = '0;
    endcase
  end
endmodule

// File: rtl/wave_voice.sv
module wave_voice
  import wv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        sync_src_msb,
  output logic [11:0] sample,
  output logic        acc_msb,
  output logic [7:0]  readback
);
  logic [FREQ_W-1:0] freq;
  logic [SMP_W-1:0]  duty;
  mode_t             mode;
  logic [ACC_W-1:0]  acc;
  logic              sync_hit;
  logic [SMP_W-1:0]  noise_word;
  logic              noise_step;
  logic [3:0]        sel;

  wv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq(freq), .duty(duty), .mode(mode)
  );

  wv_phase u_phase (
    .clk(clk), .rst_n(rst_n), .freq(freq), .test(mode.test),
    .sync_en(mode.sync), .src_msb(sync_src_msb), .acc(acc), .sync_hit(sync_hit)
  );

  wv_noise u_noise (
    .clk(clk), .rst_n(rst_n), .test(mode.test), .phase_b19(acc[19]),
    .noise_word(noise_word), .step(noise_step)
  );

  assign sel = {mode.sel_noise, mode.sel_pulse, mode.sel_saw, mode.sel_tri};

  wv_shaper u_shaper (
    .sel(sel), .top(acc[ACC_W-1 -: SMP_W]), .duty(duty),
    .noise_word(noise_word), .ring(mode.ring), .src_msb(sync_src_msb),
    .sample(sample)
  );

  assign acc_msb  = acc[ACC_W-1];
  assign readback = sample[SMP_W-1 -: 8];

  p_no_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(sel) |-> (sample == '0));
  p_pulse_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'b0100) |-> (sample == '0 || sample == {SMP_W{1'b1}}));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (sample == '0 && !acc_msb));
endmodule

// File: tb/tb_wave_voice.sv
module tb_wave_voice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        src = 1'b0;
  logic [11:0] sample;
  logic        acc_msb;
  logic [7:0]  readback;

  int vecs = 0;
  int errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_voice dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_src_msb(src), .sample(sample),
    .acc_msb(acc_msb), .readback(readback)
  );

  task automatic check(input string req, input logic [11:0] exp);
    vecs++;
    if (sample !== exp) begin
      errs++;
      $display("FAIL %s sample got %h expected %h", req, sample, exp);
    end
    vecs++;
    if (readback !== exp[11:4]) begin
      errs++;
      $display("FAIL R11 (%s) readback got %h expected %h", req, readback, exp[11:4]);
    end
  endtask

  task automatic check_msb(input string req, input logic exp);
    vecs++;
    if (acc_msb !== exp) begin
      errs++;
      $display("FAIL %s acc_msb got %b expected %b", req, acc_msb, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_freq(input logic [15:0] f);
    wr(3'd0, f[7:0]);
    wr(3'd1, f[15:8]);
  endtask

  // hold test for a moment, then release with ctrl; run k clocks
  task automatic clear_run(input logic [7:0] ctrl, input int k);
    wr(3'd4, ctrl | 8'h08);
    wr(3'd4, ctrl);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [23:0] phase_after(input logic [15:0] f, input int k);
    longint p;
    p = longint'(f) * longint'(k);
    return p[23:0];
  endfunction

  function automatic logic [11:0] tri_exp(input logic [23:0] p, input logic flip);
    logic [11:0] t;
    t = p[23:12];
    if (p[23] ^ flip) t = ~t;
    return {t[10:0], 1'b0};
  endfunction

  function automatic logic [11:0] taps(input logic [22:0] l);
    return {l[22], l[20], l[16], l[13], l[11], l[7], l[4], l[2], 4'h0};
  endfunction

  task automatic t_reset;
    check("R1 reset sample", 12'h000);
    check_msb("R1 reset msb", 1'b0);
  endtask

  task automatic t_saw;
    set_freq(16'h0102);
    clear_run(8'h20, 37);
    check("R3 saw small step", phase_after(16'h0102, 37)[23:12]);
    set_freq(16'hFFFF);
    clear_run(8'h20, 127);
    check("R3 saw", phase_after(16'hFFFF, 127)[23:12]);
    check_msb("R2 msb below half", 1'b0);
    repeat (2) @(negedge clk);
    check_msb("R2 msb above half", 1'b1);
    clear_run(8'h20, 300);
    check("R2 wrap modulo 2^24", phase_after(16'hFFFF, 300)[23:12]);
  endtask

  task automatic t_tri_ring;
    set_freq(16'h1234);
    clear_run(8'h10, 1000);
    check("R4 triangle rising half", tri_exp(phase_after(16'h1234, 1000), 1'b0));
    set_freq(16'hFFFF);
    clear_run(8'h10, 200);
    check("R4 triangle falling half", tri_exp(phase_after(16'hFFFF, 200), 1'b0));
    src = 1'b1; #1;
    check("R9 ring off ignores source", tri_exp(phase_after(16'hFFFF, 200), 1'b0));
    src = 1'b0;
    clear_run(8'h14, 200);
    check("R9 ring source low", tri_exp(phase_after(16'hFFFF, 200), 1'b0));
    src = 1'b1; #1;
    check("R9 ring source high", tri_exp(phase_after(16'hFFFF, 200), 1'b1));
    @(negedge clk);
    src = 1'b0; #1;
    check("R9 ring no phase effect", tri_exp(phase_after(16'hFFFF, 201), 1'b0));
  endtask

  task automatic t_pulse;
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hF8);   // upper nibble ignored: duty = 0x800
    set_freq(16'hFFFF);
    clear_run(8'h40, 100);
    check("R5 pulse below duty", 12'h000);
    clear_run(8'h40, 200);
    check("R5 pulse at/above duty", 12'hFFF);
  endtask

  task automatic t_noise;
    logic [23:0] a;
    logic        b;
    logic [22:0] l;
    clear_run(8'h88, 3);
    check("R7 test holds noise seed", taps(23'h7FFFF8));
    set_freq(16'hFFFF);
    clear_run(8'h80, 200);
    a = '0; b = 1'b0; l = 23'h7FFFF8;
    for (int i = 0; i < 200; i++) begin
      if (a[19] && !b) l = {l[21:0], l[22] ^ l[17]};
      b = a[19];
      a = a + 24'(16'hFFFF);
    end
    check("R6 noise after shifts", taps(l));
  endtask

  task automatic t_test;
    set_freq(16'h4000);
    wr(3'd4, 8'h28);
    repeat (10) @(negedge clk);
    check("R7 test holds phase", 12'h000);
    check_msb("R7 test msb", 1'b0);
  endtask

  task automatic t_sync;
    set_freq(16'h1000);
    clear_run(8'h22, 50);
    check("R8 before sync", phase_after(16'h1000, 50)[23:12]);
    src = 1'b1;
    @(negedge clk);
    check("R8 sync clears", 12'h000);
    repeat (3) @(negedge clk);
    check("R8 restart after sync", phase_after(16'h1000, 3)[23:12]);
    src = 1'b0;
    clear_run(8'h20, 50);
    src = 1'b1;
    @(negedge clk);
    check("R8 sync off ignored", phase_after(16'h1000, 51)[23:12]);
    src = 1'b0;
  endtask

  task automatic t_mix;
    set_freq(16'hFFFF);
    clear_run(8'h60, 150);
    check("R10 two selects", 12'h000);
    clear_run(8'h00, 150);
    check("R10 no select", 12'h000);
    clear_run(8'hF0, 150);
    check("R10 all selects", 12'h000);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    t_reset();
    rst_n = 1'b1;
    t_saw();
    t_tri_ring();
    t_pulse();
    t_noise();
    t_test();
    t_sync();
    t_mix();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule